// File: doc/BRIEF.md
# Lifecycle Transition Sequencer

This block walks a requested lifecycle transition through a fixed series of phases. Starting from idle, a request first switches the clock source. The block then increments the transition counter and programs it, checks that the transition is legal, and hashes the supplied token. When the target calls for a flash wipe, a wipe phase follows the hash. Next come the two halves of the token compare, and last the new state is programmed. The run ends in a terminal post-transition state.

A failed step sends the machine straight to post-transition. A three-bit error code records which step failed.

The machine has two further exits:
- Idle can go directly to a terminal scrap state.
- Either of two independent escalation inputs forces a terminal escalate state from any state.

State codes are sparse, so a single flipped bit lands on an illegal value. Any illegal value moves the machine to an invalid sink, which escalation can still override.

The counter/state programming agent and the hash engine are reached through simple request/response handshakes. The flash wipe is requested by a level that stays high while the machine is in the wipe phase.

Top module: `life_xfer_seq`

## Requirements
- R1: State codes are 7 bits. The code of index d is {d[3:0], p2, p1, p0}, where p0=d0^d1^d3, p1=d0^d2^d3 and p2=d1^d2^d3. The indices are: reset 1, idle 2, clock-switch 3, counter-increment 4, counter-program 5, legality-check 6, token-hash 7, flash-wipe 8, token-compare-A 9, token-compare-B 10, state-program 11, post-transition 12, scrap 13, escalate 14, invalid 15. While reset is active the state is reset and the error code is 0. The first cycle after reset goes to idle.
- R2: In idle, scrap_req_i moves to scrap. Otherwise trans_req_i moves to clock-switch. With neither asserted, the machine stays in idle. Scrap takes priority over a transition request.
- R3: Clock-switch and legality-check each last one cycle. Clock-switch goes to counter-increment. From then until reset, clk_sel_o is 1.
- R4: Counter-increment goes to counter-program. If cnt_max_i is high, it instead goes to post-transition with error code 1.
- R5: Counter-program drives prog_req_o=1 and prog_sel_o=0, and holds until prog_ack_i. An ack with prog_err_i goes to post-transition with error code 2. A clean ack goes to legality-check.
- R6: Legality-check goes to token-hash when trans_ok_i is high. Otherwise it goes to post-transition with error code 3.
- R7: Token-hash drives hash_req_o and holds until hash_valid_i. A result with hash_err_i goes to post-transition with error code 4. A clean result goes to flash-wipe if wipe_mode_i is high, else to token-compare-A. Flash-wipe drives wipe_req_o for its one cycle and then always goes to token-compare-A.
- R8: Token-compare-A goes to token-compare-B on tok_match_a_i, else to post-transition with error code 5. Token-compare-B lasts exactly one cycle. It goes to state-program on tok_match_b_i, else to post-transition with error code 6.
- R9: State-program drives prog_req_o=1 and prog_sel_o=1, and holds until prog_ack_i. An error ack goes to post-transition with error code 7. A clean ack goes to post-transition with error code 0.
- R10: Post-transition and scrap hold, and the error code stays fixed, whatever the non-escalation inputs do.
- R11: If esc_a_i or esc_b_i is high in any state, the next state is escalate, which holds until reset.
- R12: Any state value that is not one of the 15 codes moves the machine to invalid. Invalid holds, and goes to escalate when either escalation input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trans_req_i | input | 1 | Transition request |
| scrap_req_i | input | 1 | Direct scrap request from idle |
| wipe_mode_i | input | 1 | Target needs the flash wipe phase |
| cnt_max_i | input | 1 | Transition counter already saturated |
| prog_ack_i | input | 1 | Programming agent done |
| prog_err_i | input | 1 | Programming agent error, valid with ack |
| trans_ok_i | input | 1 | Requested transition is legal |
| hash_valid_i | input | 1 | Hash result ready |
| hash_err_i | input | 1 | Hash error, valid with result |
| tok_match_a_i | input | 1 | First token half matches |
| tok_match_b_i | input | 1 | Second token half matches |
| esc_a_i | input | 1 | Escalation input A |
| esc_b_i | input | 1 | Escalation input B |
| state_o | output | 7 | Current state code |
| err_o | output | 3 | Code of the failed step, 0 for none |
| clk_sel_o | output | 1 | Switched clock selected |
| prog_req_o | output | 1 | Request to the programming agent |
| prog_sel_o | output | 1 | 0 counter, 1 lifecycle state |
| hash_req_o | output | 1 | Request to the hash engine |
| wipe_req_o | output | 1 | Flash wipe request |

## Verification
The bench aims at every bail-out point, one scenario each, and checks that each failure reports its own error code. A swapped code or a missing exit would show up as a wrong error value, or as a walk that carries on to the program phase.

Both handshake waits are held for several cycles, which catches a design that advances without an ack or a valid result. The wipe-mode walk checks that the wipe phase is entered and then always leaves for the first compare. The second compare is checked for lasting only one cycle.

Escalation is raised mid-sequence, in post-transition and in the invalid sink, on each input separately. Terminal states are driven with stray requests to catch any leak out of them. A zero state value is forced to show that an illegal code lands in invalid.

// File: rtl/life_xfer_seq.sv
module life_xfer_seq #(
  parameter int unsigned ST_W  = 7,
  parameter int unsigned ERR_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trans_req_i,
  input  logic             scrap_req_i,
  input  logic             wipe_mode_i,
  input  logic             cnt_max_i,
  input  logic             prog_ack_i,
  input  logic             prog_err_i,
  input  logic             trans_ok_i,
  input  logic             hash_valid_i,
  input  logic             hash_err_i,
  input  logic             tok_match_a_i,
  input  logic             tok_match_b_i,
  input  logic             esc_a_i,
  input  logic             esc_b_i,
  output logic [ST_W-1:0]  state_o,
  output logic [ERR_W-1:0] err_o,
  output logic             clk_sel_o,
  output logic             prog_req_o,
  output logic             prog_sel_o,
  output logic             hash_req_o,
  output logic             wipe_req_o
);

  function automatic logic [6:0] sparse_code(input logic [3:0] d);
    return {d, d[1] ^ d[2] ^ d[3], d[0] ^ d[2] ^ d[3], d[0] ^ d[1] ^ d[3]};
  endfunction

  localparam logic [ST_W-1:0] S_RESET = sparse_code(4'd1);
  localparam logic [ST_W-1:0] S_IDLE  = sparse_code(4'd2);
  localparam logic [ST_W-1:0] S_CLK   = sparse_code(4'd3);
  localparam logic [ST_W-1:0] S_CINC  = sparse_code(4'd4);
  localparam logic [ST_W-1:0] S_CPRG  = sparse_code(4'd5);
  localparam logic [ST_W-1:0] S_CHK   = sparse_code(4'd6);
  localparam logic [ST_W-1:0] S_HASH  = sparse_code(4'd7);
  localparam logic [ST_W-1:0] S_WIPE  = sparse_code(4'd8);
  localparam logic [ST_W-1:0] S_TOKA  = sparse_code(4'd9);
  localparam logic [ST_W-1:0] S_TOKB  = sparse_code(4'd10);
  localparam logic [ST_W-1:0] S_SPRG  = sparse_code(4'd11);
  localparam logic [ST_W-1:0] S_POST  = sparse_code(4'd12);
  localparam logic [ST_W-1:0] S_SCRAP = sparse_code(4'd13);
  localparam logic [ST_W-1:0] S_ESC   = sparse_code(4'd14);
  localparam logic [ST_W-1:0] S_INV   = sparse_code(4'd15);

  logic [ST_W-1:0]  st_q, st_d;
  logic [ERR_W-1:0] err_q, fail_code;
  logic             clk_sel_q;
  logic             esc;

  assign esc = esc_a_i | esc_b_i;

  always_comb begin
    st_d      = st_q;
    fail_code = '0;
    case (st_q)
      S_RESET: st_d = S_IDLE;
      S_IDLE: begin
        if (scrap_req_i)      st_d = S_SCRAP;
        else if (trans_req_i) st_d = S_CLK;
      end
      S_CLK: st_d = S_CINC;
      S_CINC: begin
        if (cnt_max_i) begin st_d = S_POST; fail_code = 3'd1; end
        else                 st_d = S_CPRG;
      end
      S_CPRG: begin
        if (prog_ack_i) begin
          if (prog_err_i) begin st_d = S_POST; fail_code = 3'd2; end
          else                  st_d = S_CHK;
        end
      end
      S_CHK: begin
        if (trans_ok_i) st_d = S_HASH;
        else begin st_d = S_POST; fail_code = 3'd3; end
      end
      S_HASH: begin
        if (hash_valid_i) begin
          if (hash_err_i)       begin st_d = S_POST; fail_code = 3'd4; end
          else if (wipe_mode_i) st_d = S_WIPE;
          else                  st_d = S_TOKA;
        end
      end
      S_WIPE: st_d = S_TOKA;
      S_TOKA: begin
        if (tok_match_a_i) st_d = S_TOKB;
        else begin st_d = S_POST; fail_code = 3'd5; end
      end
      S_TOKB: begin
        if (tok_match_b_i) st_d = S_SPRG;
        else begin st_d = S_POST; fail_code = 3'd6; end
      end
      S_SPRG: begin
        if (prog_ack_i) begin
          st_d = S_POST;
          if (prog_err_i) fail_code = 3'd7;
        end
      end
      S_POST, S_SCRAP, S_ESC, S_INV: st_d = st_q;
      default: st_d = S_INV;
    endcase
    if (esc) begin
      st_d      = S_ESC;
      fail_code = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_RESET;
      err_q     <= '0;
      clk_sel_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (fail_code != '0) err_q <= fail_code;
      if (st_q == S_CLK) clk_sel_q <= 1'b1;
    end
  end

  assign state_o    = st_q;
  assign err_o      = err_q;
  assign clk_sel_o  = clk_sel_q;
  assign prog_req_o = (st_q == S_CPRG) || (st_q == S_SPRG);
  assign prog_sel_o = (st_q == S_SPRG);
  assign hash_req_o = (st_q == S_HASH);
  assign wipe_req_o = (st_q == S_WIPE);

endmodule

// File: rtl/life_xfer_seq_chk.sv
module life_xfer_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       esc_a_i,
  input logic       esc_b_i,
  input logic [6:0] state_o,
  input logic [2:0] err_o,
  input logic       prog_req_o,
  input logic       prog_sel_o
);

  function automatic logic [6:0] code_of(input int unsigned i);
    logic [3:0] d;
    d = 4'(i);
    return {d, d[1] ^ d[2] ^ d[3], d[0] ^ d[2] ^ d[3], d[0] ^ d[1] ^ d[3]};
  endfunction

  function automatic logic is_legal(input logic [6:0] s);
    logic hit;
    hit = 1'b0;
    for (int i = 1; i <= 15; i++) if (s == code_of(i)) hit = 1'b1;
    return hit;
  endfunction

  logic esc;
  assign esc = esc_a_i | esc_b_i;

  a_r1_reset_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == code_of(1) && !esc) |=> state_o == code_of(2));

  a_r8_tokb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == code_of(10) |=> state_o != code_of(10));

  a_r10_post_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == code_of(12) && !esc) |=> (state_o == code_of(12) && $stable(err_o)));

  a_r10_scrap_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == code_of(13) && !esc) |=> state_o == code_of(13));

  a_r11_escalate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc |=> state_o == code_of(14));

  a_r11_esc_terminal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == code_of(14) |=> state_o == code_of(14));

  a_r12_illegal_sink: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_legal(state_o) && !esc) |=> state_o == code_of(15));

  a_r5_prog_req_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |-> ((state_o == code_of(5) && !prog_sel_o) || (state_o == code_of(11) && prog_sel_o)));

endmodule

bind life_xfer_seq life_xfer_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .esc_a_i(esc_a_i), .esc_b_i(esc_b_i),
  .state_o(state_o), .err_o(err_o), .prog_req_o(prog_req_o), .prog_sel_o(prog_sel_o)
);

// File: tb/test_life_xfer_seq.sv
module test_life_xfer_seq;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic trans_req, scrap_req, wipe_mode, cnt_max, prog_ack, prog_err, trans_ok;
  logic hash_valid, hash_err, tok_a, tok_b, esc_a, esc_b;
  logic [6:0] state;
  logic [2:0] err;
  logic clk_sel, prog_req, prog_sel, hash_req, wipe_req;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  typedef struct {
    int    idx;
    int    er;
    string tag;
  } exp_t;
  exp_t q[$];
  exp_t it;

  always #(CLK_PERIOD/2) clk = ~clk;

  life_xfer_seq i_life_xfer_seq (
    .clk_i(clk), .rst_ni(rst_ni), .trans_req_i(trans_req), .scrap_req_i(scrap_req),
    .wipe_mode_i(wipe_mode), .cnt_max_i(cnt_max), .prog_ack_i(prog_ack), .prog_err_i(prog_err),
    .trans_ok_i(trans_ok), .hash_valid_i(hash_valid), .hash_err_i(hash_err),
    .tok_match_a_i(tok_a), .tok_match_b_i(tok_b), .esc_a_i(esc_a), .esc_b_i(esc_b),
    .state_o(state), .err_o(err), .clk_sel_o(clk_sel), .prog_req_o(prog_req),
    .prog_sel_o(prog_sel), .hash_req_o(hash_req), .wipe_req_o(wipe_req)
  );

  function automatic logic [6:0] code_of(input int i);
    logic [3:0] d;
    d = 4'(i);
    return {d, d[1] ^ d[2] ^ d[3], d[0] ^ d[2] ^ d[3], d[0] ^ d[1] ^ d[3]};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      chk({it.tag, " state"}, int'(state), int'(code_of(it.idx)));
      chk({it.tag, " err"}, int'(err), it.er);
      chk({it.tag, " handshakes"}, int'({prog_req, prog_sel, hash_req, wipe_req}),
          int'({it.idx == 5 || it.idx == 11, it.idx == 11, it.idx == 7, it.idx == 8}));
    end
  end

  task automatic tick(input int idx, input int er, input string tag);
    exp_t e;
    e.idx = idx; e.er = er; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic clr();
    {trans_req, scrap_req, wipe_mode, cnt_max, prog_ack, prog_err, trans_ok} = '0;
    {hash_valid, hash_err, tok_a, tok_b, esc_a, esc_b} = '0;
  endtask

  task automatic do_reset();
    clr();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset state", int'(state), int'(code_of(1)));
    chk("R1 reset err", int'(err), 0);
    chk("R3 clk_sel in reset", int'(clk_sel), 0);
    rst_ni = 1'b1;
  endtask

  task automatic go_to(input int tgt, input bit wipe);
    tick(2, 0, "R1 to idle"); if (tgt == 2) return;
    trans_req = 1; tick(3, 0, "R2 request"); trans_req = 0; if (tgt == 3) return;
    tick(4, 0, "R3 clock switch"); if (tgt == 4) return;
    tick(5, 0, "R4 increment"); if (tgt == 5) return;
    prog_ack = 1; tick(6, 0, "R5 counter ack"); prog_ack = 0; if (tgt == 6) return;
    trans_ok = 1; tick(7, 0, "R6 legal"); if (tgt == 7) return;
    hash_valid = 1; wipe_mode = wipe;
    if (wipe) begin
      tick(8, 0, "R7 to wipe"); hash_valid = 0; if (tgt == 8) return;
    end
    tick(9, 0, "R7 to compare A"); hash_valid = 0; if (tgt == 9) return;
    tok_a = 1; tick(10, 0, "R8 match A"); if (tgt == 10) return;
    tok_b = 1; tick(11, 0, "R8 match B");
  endtask

  initial begin
    @(negedge clk);
    // full walk with handshake waits
    do_reset();
    tick(2, 0, "R1 to idle");
    tick(2, 0, "R2 idle hold");
    trans_req = 1; tick(3, 0, "R2 request"); trans_req = 0;
    tick(4, 0, "R3 clock switch one cycle");
    chk("R3 clk_sel raised", int'(clk_sel), 1);
    tick(5, 0, "R4 increment");
    tick(5, 0, "R5 wait ack 1");
    tick(5, 0, "R5 wait ack 2");
    prog_ack = 1; tick(6, 0, "R5 counter ack"); prog_ack = 0;
    trans_ok = 1; tick(7, 0, "R6 legal");
    tick(7, 0, "R7 hash wait 1");
    tick(7, 0, "R7 hash wait 2");
    hash_valid = 1; tick(9, 0, "R7 no wipe"); hash_valid = 0;
    tok_a = 1; tick(10, 0, "R8 match A");
    tok_b = 1; tick(11, 0, "R8 compare B single cycle");
    tick(11, 0, "R9 wait ack");
    prog_ack = 1; tick(12, 0, "R9 clean finish"); prog_ack = 0;
    trans_req = 1; scrap_req = 1; prog_ack = 1; prog_err = 1; hash_valid = 1; hash_err = 1;
    tick(12, 0, "R10 post ignores inputs");
    tick(12, 0, "R10 post ignores inputs 2");
    chk("R3 clk_sel held", int'(clk_sel), 1);
    clr(); esc_b = 1; tick(14, 0, "R11 esc B from post"); esc_b = 0;

    // wipe path, compare A mismatch
    do_reset(); go_to(8, 1'b1);
    tick(9, 0, "R7 wipe always to compare A");
    tok_a = 0; tick(12, 5, "R8 mismatch A");

    // each bail-out
    do_reset(); go_to(4, 0); cnt_max = 1; tick(12, 1, "R4 saturated");
    do_reset(); go_to(5, 0); prog_ack = 1; prog_err = 1; tick(12, 2, "R5 error ack");
    do_reset(); go_to(6, 0); trans_ok = 0; tick(12, 3, "R6 illegal transition");
    do_reset(); go_to(7, 0); hash_valid = 1; hash_err = 1; tick(12, 4, "R7 hash error");
    do_reset(); go_to(10, 0); tok_b = 0; tick(12, 6, "R8 mismatch B");
    do_reset(); go_to(11, 0); prog_ack = 1; prog_err = 1; tick(12, 7, "R9 error ack");
    prog_err = 0; tick(12, 7, "R10 error code held");

    // scrap priority and hold
    do_reset(); go_to(2, 0);
    scrap_req = 1; trans_req = 1; tick(13, 0, "R2 scrap priority");
    scrap_req = 0; tick(13, 0, "R10 scrap holds");
    tick(13, 0, "R10 scrap holds 2");

    // escalation mid-sequence
    do_reset(); go_to(7, 0);
    esc_a = 1; tick(14, 0, "R11 esc A in hash"); esc_a = 0;
    trans_req = 1; tick(14, 0, "R11 escalate terminal");
    do_reset(); go_to(3, 0);
    esc_b = 1; tick(14, 0, "R11 esc B in clock switch"); esc_b = 0;
    tick(14, 0, "R11 escalate terminal B");

    // illegal code to invalid, then escalation
    do_reset(); go_to(6, 0);
    force i_life_xfer_seq.st_q = 7'd0;
    #1 release i_life_xfer_seq.st_q;
    tick(15, 0, "R12 illegal to invalid");
    trans_req = 1; tick(15, 0, "R12 invalid holds"); trans_req = 0;
    esc_a = 1; tick(14, 0, "R12 invalid to escalate"); esc_a = 0;

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule